// File: doc/BRIEF.md
# Duty Ratio Search Engine

This engine picks the run/stall counts for a clock-throttling scheme. The processor core runs for OFF intervals and is held suspended for ON intervals. The effective rate is therefore the full rate scaled by OFF / (ON + OFF). Given a requested rate and the full rate, both in kHz, the engine tries every candidate total from an upper bound down to 1. It keeps the count pair whose resulting rate lies nearest to the request.

A search is launched with a start pulse. The engine captures its inputs and works through the candidates one at a time on a single shared iterative divider. When it finishes, it reports the ON count, the OFF count, the achieved rate and a modulation enable. A result equal to the full rate means throttling is off, and it is reported as zero counts with the enable low.

Top module: `duty_search`

## Requirements
- R1: A start pulse seen while idle begins a search, and busy is high from the next cycle. The search ends with done high for exactly one cycle, and busy is low in that cycle. The results stay unchanged until the next done. After reset, busy, done, mod_en, on_cnt, off_cnt and achieved_khz are all 0.
- R2: The running best begins as (rate = stock, ON = 0, OFF = 1). Candidate totals i are visited from the clamped maximum down to 1, one after another.
- R3: For each total i, OFF = floor(target·i / stock) mod 256 and ON = (i − OFF) mod 256. The candidate rate is floor(stock·OFF / i). stock must be nonzero.
- R4: A candidate becomes the new best when |rate − target| ≤ |best − target|. On equal error the later, smaller total wins. A candidate with a larger error leaves the best unchanged.
- R5: If the final best rate equals stock, the outputs are on_cnt = 0, off_cnt = 0 and mod_en = 0. Otherwise mod_en = 1 and the best counts are output. achieved_khz always carries the best rate.
- R6: A max_total above 255 is treated as 255.
- R7: A max_total of 0 visits no candidate, and the result is achieved_khz = stock with mod_en = 0.
- R8: While busy, start pulses are ignored and changes on target_khz, stock_khz and max_total have no effect on the search under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Launch a search (taken only when idle) |
| target_khz | input | FREQ_W | Requested rate in kHz |
| stock_khz | input | FREQ_W | Full rate in kHz, nonzero |
| max_total | input | MAXIN_W | Upper bound on ON + OFF, clamped to 255 |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when results are updated |
| on_cnt | output | 8 | Suspended interval count |
| off_cnt | output | 8 | Running interval count |
| achieved_khz | output | FREQ_W+8 | Rate reached by the chosen pair |
| mod_en | output | 1 | Throttling enable, low for a full-rate result |

## Verification
Several checks run on every cycle. Every division the engine performs must return a quotient and remainder that rebuild the dividend exactly. The total index must fall by one per candidate and stop after 1. The best error may never grow within a search, and a worse candidate must leave the best untouched. The captured inputs must hold while busy, done must be a single-cycle pulse with busy low, and a full-rate result must always come out as zero counts. Only the bench scenarios can show that the chosen pair is the right one overall: that ties go to the smaller total, that clamping and an empty range behave as stated, and that stray starts mid-search leave the result unchanged.

// File: rtl/dsearch_pkg.sv
`timescale 1ns/1ps
package dsearch_pkg;
  localparam int unsigned CNT_W = 8;
  localparam logic [CNT_W-1:0] CNT_CAP = 8'd255;

  typedef enum logic [2:0] {
    S_IDLE, S_OFF_GO, S_OFF_WAIT, S_FRQ_GO, S_FRQ_WAIT, S_CMP, S_FINISH
  } st_e;
endpackage

// File: rtl/dsearch_div.sv
`timescale 1ns/1ps
// Restoring divider: one quotient bit per cycle, NUM_W cycles per division.
module dsearch_div #(
  parameter int unsigned NUM_W = 26,
  parameter int unsigned DEN_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             fin,
  output logic [NUM_W-1:0] quo
);
  localparam int unsigned STEP_W = $clog2(NUM_W + 1);
  localparam int unsigned WIDE_W = NUM_W + DEN_W;
  localparam logic [STEP_W-1:0] LAST = STEP_W'(NUM_W - 1);

  logic [NUM_W-1:0]  acc_q, acc_n, num_q, num_n;
  logic [DEN_W-1:0]  rem_q, rem_n, den_q, den_n;
  logic [STEP_W-1:0] step_q, step_n;
  logic              run_q, run_n, fin_q, fin_n, dp_en;
  logic [DEN_W:0]    trial;
  logic [DEN_W-1:0]  diff;
  logic              fits;

  always_comb begin
    trial  = {rem_q, acc_q[NUM_W-1]};
    fits   = trial >= {1'b0, den_q};
    diff   = trial[DEN_W-1:0] - den_q;
    acc_n  = acc_q;
    rem_n  = rem_q;
    den_n  = den_q;
    num_n  = num_q;
    step_n = step_q;
    run_n  = run_q;
    fin_n  = 1'b0;
    dp_en  = go | run_q;
    if (go) begin
      acc_n  = num;
      rem_n  = '0;
      den_n  = den;
      num_n  = num;
      step_n = '0;
      run_n  = 1'b1;
    end else if (run_q) begin
      acc_n  = {acc_q[NUM_W-2:0], fits};
      rem_n  = fits ? diff : trial[DEN_W-1:0];
      step_n = step_q + 1'b1;
      if (step_q == LAST) begin
        run_n = 1'b0;
        fin_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      num_q  <= '0;
      step_q <= '0;
      run_q  <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      fin_q <= fin_n;
      if (dp_en) begin
        acc_q  <= acc_n;
        rem_q  <= rem_n;
        den_q  <= den_n;
        num_q  <= num_n;
        step_q <= step_n;
        run_q  <= run_n;
      end
    end
  end

  assign fin = fin_q;
  assign quo = acc_q;

  // R3: quotient and remainder rebuild the dividend exactly
  p_div_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_q && den_q != '0) |->
      (WIDE_W'(acc_q) * WIDE_W'(den_q) + WIDE_W'(rem_q) == WIDE_W'(num_q)));
  // R3: remainder stays below the divisor
  p_rem_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_q && den_q != '0) |-> (rem_q < den_q));
  p_fin_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |=> !fin_q);
endmodule

// File: rtl/dsearch_ctrl.sv
`timescale 1ns/1ps
// Sequencer: captures inputs, walks totals downward, feeds the divider.
module dsearch_ctrl
  import dsearch_pkg::*;
#(
  parameter int unsigned FREQ_W  = 18,
  parameter int unsigned MAXIN_W = 16,
  parameter int unsigned PROD_W  = FREQ_W + CNT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FREQ_W-1:0]  target,
  input  logic [FREQ_W-1:0]  stock,
  input  logic [MAXIN_W-1:0] max_in,
  input  logic               div_fin,
  input  logic [CNT_W-1:0]   div_q_lo,
  output logic               busy,
  output logic               div_go,
  output logic [PROD_W-1:0]  div_num,
  output logic [FREQ_W-1:0]  div_den,
  output logic               best_init,
  output logic               best_cmp,
  output logic               best_commit,
  output logic [CNT_W-1:0]   cand_on,
  output logic [CNT_W-1:0]   cand_off,
  output logic [FREQ_W-1:0]  tgt_cap,
  output logic [FREQ_W-1:0]  stk_cap
);
  st_e               st_q, st_n;
  logic [FREQ_W-1:0] tgt_q, stk_q;
  logic [CNT_W-1:0]  i_q, i_n, off_q, off_n, clamp;
  logic              cap_en;

  always_comb begin
    clamp = (max_in > MAXIN_W'(CNT_CAP)) ? CNT_CAP : max_in[CNT_W-1:0];
    st_n        = st_q;
    i_n         = i_q;
    off_n       = off_q;
    cap_en      = 1'b0;
    div_go      = 1'b0;
    div_num     = '0;
    div_den     = '0;
    best_init   = 1'b0;
    best_cmp    = 1'b0;
    best_commit = 1'b0;
    unique case (st_q)
      S_IDLE: if (start) begin
        cap_en    = 1'b1;
        best_init = 1'b1;
        i_n       = clamp;
        st_n      = (clamp == '0) ? S_FINISH : S_OFF_GO;
      end
      S_OFF_GO: begin
        div_go  = 1'b1;
        div_num = PROD_W'(tgt_q) * PROD_W'(i_q);
        div_den = stk_q;
        st_n    = S_OFF_WAIT;
      end
      S_OFF_WAIT: if (div_fin) begin
        off_n = div_q_lo;
        st_n  = S_FRQ_GO;
      end
      S_FRQ_GO: begin
        div_go  = 1'b1;
        div_num = PROD_W'(stk_q) * PROD_W'(off_q);
        div_den = FREQ_W'(i_q);
        st_n    = S_FRQ_WAIT;
      end
      S_FRQ_WAIT: if (div_fin) st_n = S_CMP;
      S_CMP: begin
        best_cmp = 1'b1;
        if (i_q == CNT_W'(1)) begin
          st_n = S_FINISH;
        end else begin
          i_n  = i_q - 1'b1;
          st_n = S_OFF_GO;
        end
      end
      S_FINISH: begin
        best_commit = 1'b1;
        st_n        = S_IDLE;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      tgt_q <= '0;
      stk_q <= '0;
      i_q   <= '0;
      off_q <= '0;
    end else begin
      st_q  <= st_n;
      i_q   <= i_n;
      off_q <= off_n;
      if (cap_en) begin
        tgt_q <= target;
        stk_q <= stock;
      end
    end
  end

  assign busy     = (st_q != S_IDLE);
  assign cand_off = off_q;
  assign cand_on  = i_q - off_q;
  assign tgt_cap  = tgt_q;
  assign stk_cap  = stk_q;

  // R2: each new candidate uses a total one below the previous
  p_index_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_OFF_GO && $past(st_q) == S_CMP) |-> (i_q == $past(i_q) - 1'b1));
  // R2: total 1 is the last candidate
  p_last_total_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_CMP && i_q == CNT_W'(1)) |=> (st_q == S_FINISH));
  // R6: oversized bound starts the walk at 255
  p_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE && start && max_in > MAXIN_W'(CNT_CAP)) |=> (i_q == CNT_CAP));
  // R8: captured inputs do not move during a search
  p_hold_inputs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != S_IDLE) |=> ($stable(tgt_q) && $stable(stk_q)));
endmodule

// File: rtl/dsearch_best.sv
`timescale 1ns/1ps
// Keeps the closest pair found so far and maps it to the result registers.
module dsearch_best
  import dsearch_pkg::*;
#(
  parameter int unsigned FREQ_W = 18,
  parameter int unsigned PROD_W = FREQ_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic [FREQ_W-1:0] init_stock,
  input  logic [FREQ_W-1:0] tgt,
  input  logic [FREQ_W-1:0] stk,
  input  logic              cmp,
  input  logic [PROD_W-1:0] cand_freq,
  input  logic [CNT_W-1:0]  cand_on,
  input  logic [CNT_W-1:0]  cand_off,
  input  logic              commit,
  output logic [CNT_W-1:0]  res_on,
  output logic [CNT_W-1:0]  res_off,
  output logic [PROD_W-1:0] res_freq,
  output logic              res_en,
  output logic              res_done
);
  logic [PROD_W-1:0] best_q, best_n, t_ext, best_err, cand_err, rf_n;
  logic [CNT_W-1:0]  bon_q, bon_n, boff_q, boff_n, ron_n, roff_n;
  logic              take, full, best_en, ren_n;
  logic [PROD_W-1:0] rf_q;
  logic [CNT_W-1:0]  ron_q, roff_q;
  logic              ren_q, done_q;

  always_comb begin
    t_ext    = PROD_W'(tgt);
    best_err = (best_q >= t_ext) ? best_q - t_ext : t_ext - best_q;
    cand_err = (cand_freq >= t_ext) ? cand_freq - t_ext : t_ext - cand_freq;
    take     = cmp && (cand_err <= best_err);
    best_en  = init | take;
    best_n   = best_q;
    bon_n    = bon_q;
    boff_n   = boff_q;
    if (init) begin
      best_n = PROD_W'(init_stock);
      bon_n  = '0;
      boff_n = CNT_W'(1);
    end else if (take) begin
      best_n = cand_freq;
      bon_n  = cand_on;
      boff_n = cand_off;
    end
    full   = (best_q == PROD_W'(stk));
    rf_n   = best_q;
    ron_n  = full ? '0 : bon_q;
    roff_n = full ? '0 : boff_q;
    ren_n  = !full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_q <= '0;
      bon_q  <= '0;
      boff_q <= '0;
      rf_q   <= '0;
      ron_q  <= '0;
      roff_q <= '0;
      ren_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= commit;
      if (best_en) begin
        best_q <= best_n;
        bon_q  <= bon_n;
        boff_q <= boff_n;
      end
      if (commit) begin
        rf_q   <= rf_n;
        ron_q  <= ron_n;
        roff_q <= roff_n;
        ren_q  <= ren_n;
      end
    end
  end

  assign res_on   = ron_q;
  assign res_off  = roff_q;
  assign res_freq = rf_q;
  assign res_en   = ren_q;
  assign res_done = done_q;

  // R4: the best error never grows after a comparison
  p_err_nonincrease_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmp |=> (best_err <= $past(best_err)));
  // R4: a worse candidate leaves the best untouched
  p_keep_on_worse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp && cand_err > best_err) |=> ($stable(best_q) && $stable(bon_q) && $stable(boff_q)));
  // R5: a full-rate result carries zero counts and the stock rate
  p_full_rate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !ren_q) |-> (ron_q == '0 && roff_q == '0 && rf_q == PROD_W'(stk)));
  // R1: done lasts a single cycle
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/duty_search.sv
`timescale 1ns/1ps
module duty_search
  import dsearch_pkg::*;
#(
  parameter int unsigned FREQ_W  = 18,
  parameter int unsigned MAXIN_W = 16,
  localparam int unsigned PROD_W = FREQ_W + CNT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FREQ_W-1:0]  target_khz,
  input  logic [FREQ_W-1:0]  stock_khz,
  input  logic [MAXIN_W-1:0] max_total,
  output logic               busy,
  output logic               done,
  output logic [CNT_W-1:0]   on_cnt,
  output logic [CNT_W-1:0]   off_cnt,
  output logic [PROD_W-1:0]  achieved_khz,
  output logic               mod_en
);
  logic [1:0]        rsync_q;
  logic              rst_i;
  logic              div_go, div_fin, b_init, b_cmp, b_commit;
  logic [PROD_W-1:0] div_num, div_quo;
  logic [FREQ_W-1:0] div_den, tgt_c, stk_c;
  logic [CNT_W-1:0]  c_on, c_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i = rsync_q[1];

  dsearch_ctrl #(.FREQ_W(FREQ_W), .MAXIN_W(MAXIN_W), .PROD_W(PROD_W)) u_ctrl (
    .clk(clk), .rst_n(rst_i), .start(start), .target(target_khz),
    .stock(stock_khz), .max_in(max_total), .div_fin(div_fin),
    .div_q_lo(div_quo[CNT_W-1:0]), .busy(busy), .div_go(div_go),
    .div_num(div_num), .div_den(div_den), .best_init(b_init),
    .best_cmp(b_cmp), .best_commit(b_commit), .cand_on(c_on),
    .cand_off(c_off), .tgt_cap(tgt_c), .stk_cap(stk_c)
  );

  dsearch_div #(.NUM_W(PROD_W), .DEN_W(FREQ_W)) u_div (
    .clk(clk), .rst_n(rst_i), .go(div_go), .num(div_num), .den(div_den),
    .fin(div_fin), .quo(div_quo)
  );

  dsearch_best #(.FREQ_W(FREQ_W), .PROD_W(PROD_W)) u_best (
    .clk(clk), .rst_n(rst_i), .init(b_init), .init_stock(stock_khz),
    .tgt(tgt_c), .stk(stk_c), .cmp(b_cmp), .cand_freq(div_quo),
    .cand_on(c_on), .cand_off(c_off), .commit(b_commit),
    .res_on(on_cnt), .res_off(off_cnt), .res_freq(achieved_khz),
    .res_en(mod_en), .res_done(done)
  );

  // R1: busy is already low in the cycle done pulses
  p_busy_done_r1: assert property (@(posedge clk) disable iff (!rst_i)
    done |-> !busy);
endmodule

// File: tb/sim_duty_search.sv
`timescale 1ns/1ps
module sim_duty_search;
  localparam int FW = 18;
  localparam int PW = FW + 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [FW-1:0] target_khz = '0;
  logic [FW-1:0] stock_khz = '0;
  logic [15:0]   max_total = '0;
  logic          busy, done, mod_en;
  logic [7:0]    on_cnt, off_cnt;
  logic [PW-1:0] achieved_khz;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  duty_search u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .target_khz(target_khz),
    .stock_khz(stock_khz), .max_total(max_total), .busy(busy), .done(done),
    .on_cnt(on_cnt), .off_cnt(off_cnt), .achieved_khz(achieved_khz), .mod_en(mod_en)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog: actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference model built from R2..R7
  task automatic model(input longint t, input longint s, input longint m,
                       output longint e_on, output longint e_off,
                       output longint e_f, output bit e_en);
    longint best, bon, boff, o, n, c, ec, eb, mm;
    mm = (m > 255) ? 255 : m;
    best = s; bon = 0; boff = 1;
    for (longint i = mm; i > 0; i--) begin
      o  = ((t * i) / s) & 255;
      n  = (i - o) & 255;
      c  = (s * o) / i;
      ec = (c >= t) ? c - t : t - c;
      eb = (best >= t) ? best - t : t - best;
      if (ec <= eb) begin best = c; bon = n; boff = o; end
    end
    e_f = best;
    if (best == s) begin e_on = 0; e_off = 0; e_en = 1'b0; end
    else begin e_on = bon; e_off = boff; e_en = 1'b1; end
  endtask

  task automatic run_search(input longint t, input longint s, input longint m,
                            input bit poke, input string req);
    longint e_on, e_off, e_f;
    bit     e_en;
    int     n;
    model(t, s, m, e_on, e_off, e_f, e_en);
    @(negedge clk);
    target_khz = FW'(t); stock_khz = FW'(s); max_total = 16'(m); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R1", "busy after start", longint'(busy), 1);
    if (poke) begin
      // R8: stray start and moving inputs while busy
      repeat (5) @(negedge clk);
      target_khz = FW'(s / 3); stock_khz = FW'(s / 2 + 7); max_total = 16'd3; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk(done == 1'b1, "R1", "done reached", longint'(done), 1);
    chk(busy == 1'b0, "R1", "busy low with done", longint'(busy), 0);
    chk(longint'(on_cnt) == e_on, req, "on_cnt", longint'(on_cnt), e_on);
    chk(longint'(off_cnt) == e_off, req, "off_cnt", longint'(off_cnt), e_off);
    chk(longint'(achieved_khz) == e_f, req, "achieved_khz", longint'(achieved_khz), e_f);
    chk(mod_en == e_en, req, "mod_en", longint'(mod_en), longint'(e_en));
    target_khz = '0; stock_khz = 18'd1; max_total = 16'd7;
    @(negedge clk);
    chk(done == 1'b0, "R1", "done one cycle", longint'(done), 0);
    chk(longint'(achieved_khz) == e_f && longint'(off_cnt) == e_off, "R1",
        "result held", longint'(achieved_khz), e_f);
  endtask

  initial begin
    longint s, t, m;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy == 1'b0 && done == 1'b0, "R1", "reset busy/done", longint'({busy, done}), 0);
    chk(mod_en == 1'b0 && on_cnt == 8'd0 && off_cnt == 8'd0, "R1", "reset counts",
        longint'({mod_en, on_cnt, off_cnt}), 0);
    chk(achieved_khz == '0, "R1", "reset achieved", longint'(achieved_khz), 0);

    run_search(500, 1000, 4, 1'b0, "R4");          // tie resolved to total 2
    run_search(1000, 1000, 20, 1'b0, "R5");        // target equals stock
    run_search(12345, 99999, 0, 1'b0, "R7");       // empty range
    run_search(1, 77777, 1, 1'b0, "R2");           // single total, off = 0
    run_search(33333, 200000, 1000, 1'b0, "R6");   // clamped to 255
    run_search(70001, 210000, 16'hFFFF, 1'b1, "R8"); // stray start mid-search
    run_search(150000, 100000, 9, 1'b0, "R3");     // target above stock, wraps
    for (int k = 0; k < 25; k++) begin
      s = 1000 + longint'($urandom % 199000);
      t = longint'($urandom) % (s + 1);
      m = 1 + longint'($urandom % 40);
      run_search(t, s, m, (k % 6) == 0, "R3");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule